// File: doc/BRIEF.md
# Half-Duplex Transmit Status Tracker

This block follows one Ethernet frame through each of its transmit attempts on a half-duplex MII link and produces the final transmit status word. An attempt is opened with a start strobe. The block then holds off while another station's carrier is present and times that wait. Once the line is quiet it grants transmission. While the frame goes out it watches the byte strobes, carrier sense, collision and data-underflow inputs.

Every attempt ends with exactly one of three one-cycle pulses. Retry means the frame collided inside the collision window and may be sent again after backoff. Abort means the frame is dropped. Done means the frame was sent. A 12-bit status word is updated on the same edge as the pulse. The external backoff logic reopens the frame with a start strobe that does not mark a new frame, and in that case the collision count carries over. The fields of the status word are not independent: the collision count reads zero once the collision limit has been hit, the late-collision flag is suppressed when underflow is reported, and loss of carrier is reported only for frames that had no collision.

Top module: `hd_tx_status_tracker`

## Requirements
- R1: The status word packs as: bit 11 loss of carrier, bit 10 no carrier, bit 9 late collision, bit 8 excessive collision, bit 7 VLAN, bits 6:3 collision count, bit 2 excessive deferral, bit 1 underflow, bit 0 deferred.
- R2: After a start, `tx_go` stays low while `crs` is high. It rises one cycle after the first cycle in which `crs` is low. Any cycle of waiting on carrier sets bit 0.
- R3: With `cfg_defer_chk` high, a wait longer than DEFER_LIMIT_BITS bit times (BITS_PER_CLK bit times per clock) aborts the attempt and sets bits 2 and 0. With `cfg_defer_chk` low, no deferral abort occurs.
- R4: A collision seen after fewer than WINDOW_BYTES byte strobes in the attempt raises `retry_pulse`. It also increments the collision count, which bits 6:3 report.
- R5: A collision seen after WINDOW_BYTES or more byte strobes aborts the attempt and sets bit 9. The collision count is left unchanged.
- R6: The COLL_LIMIT-th in-window collision of a frame aborts it and sets bit 8. Bits 6:3 then read 0.
- R7: With `cfg_no_retry` high, the first in-window collision aborts the frame and sets bit 8. Without a collision, `cfg_no_retry` has no effect.
- R8: Underflow during transmission aborts the attempt and sets bit 1. It takes priority over a collision in the same cycle, so bit 9 stays clear.
- R9: Bit 11 is set when `crs` was high in some transmit cycle and low in another, but only if the frame had no collision.
- R10: Bit 10 is set when `crs` was never high during transmission, and bit 11 is then clear.
- R11: Bit 7 holds the `vlan` input sampled with the start strobe.
- R12: `tx_active` low in a transmit cycle with no underflow or collision raises `done_pulse`. Each attempt raises exactly one one-cycle pulse among retry, abort and done.
- R13: A start with `att_new_frame` high clears the status word and the collision count. A start with it low keeps the count.
- R14: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock (one nibble per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| att_start | input | 1 | Opens an attempt (ignored unless idle) |
| att_new_frame | input | 1 | Marks the start as a new frame |
| tx_active | input | 1 | Frame data still to send; low ends the attempt |
| byte_stb | input | 1 | One pulse per byte time on the wire |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| underflow | input | 1 | Transmit data arrived late |
| vlan | input | 1 | Frame is a VLAN frame |
| cfg_no_retry | input | 1 | Abort on first collision |
| cfg_defer_chk | input | 1 | Enable the deferral limit |
| tx_go | output | 1 | Transmission granted |
| retry_pulse | output | 1 | Attempt ended, retry after backoff |
| abort_pulse | output | 1 | Attempt ended, frame dropped |
| done_pulse | output | 1 | Frame sent |
| status | output | 12 | Packed transmit status word |

## Verification
The bench builds the block with WINDOW_BYTES of 8 and DEFER_LIMIT_BITS of 40 at 4 bits per clock, a deferral limit of 10 clocks. This puts both sides of the late-collision boundary (7 and 8 strobes) and both sides of the deferral limit (10 and 11 waiting cycles) within a few cycles of stimulus. COLL_LIMIT keeps its default of 16, so the bench walks a whole frame through fifteen retries to the excessive-collision abort. It checks that the count reads 15 on the last retry and 0 once bit 8 is set.

// File: rtl/hdts_pkg.sv
// Shared types for the half-duplex transmit status tracker.
// Assumes: the status layout below is decoded by a neighbour, so field order is fixed.
package hdts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_XMIT  = 2'd2
    } hdts_state_e;

    // Packed status word, first field is bit 11.
    typedef struct packed {
        logic       carrier_lost;
        logic       carrier_none;
        logic       coll_late;
        logic       coll_excess;
        logic       is_vlan;
        logic [3:0] coll_count;
        logic       defer_excess;
        logic       data_late;
        logic       deferred;
    } hdts_status_t;

    localparam int STATUS_W = $bits(hdts_status_t);

endpackage

// File: rtl/hdts_defer_timer.sv
// Deferral timer: counts clocks spent waiting on carrier within one attempt.
// Assumes: each clock stands for BITS_PER_CLK bit times. 'expired' is high once
// LIMIT_CLKS waiting clocks have passed, so one more waiting clock exceeds the limit.
module hdts_defer_timer #(
    parameter int DEFER_LIMIT_BITS = 24288,
    parameter int BITS_PER_CLK     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int LIMIT_CLKS = DEFER_LIMIT_BITS / BITS_PER_CLK;
    localparam int CNT_W      = $clog2(LIMIT_CLKS + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT_CLKS);

    logic [CNT_W-1:0] cnt_q;

    // Saturating count of waiting clocks, cleared per attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LIMIT_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIMIT_V);

endmodule

// File: rtl/hdts_byte_window.sv
// Collision window counter: counts byte strobes since the attempt began transmitting.
// Assumes: the preamble is strobed like data. 'past_window' reflects strobes before
// the current cycle.
module hdts_byte_window #(
    parameter int WINDOW_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic stb,
    output logic past_window
);
    localparam int CNT_W = $clog2(WINDOW_BYTES + 1);
    localparam logic [CNT_W-1:0] WIN_V = CNT_W'(WINDOW_BYTES);

    logic [CNT_W-1:0] cnt_q;

    // Saturating byte-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (stb && cnt_q != WIN_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign past_window = (cnt_q == WIN_V);

endmodule

// File: rtl/hdts_carrier_mon.sv
// Carrier monitor: records whether carrier sense was ever high and ever low
// during the transmit phase of an attempt. The outputs include the current cycle.
// Assumes: 'enable' is high only in transmit cycles.
module hdts_carrier_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic crs,
    output logic seen,
    output logic lost
);
    logic seen_q;
    logic lost_q;

    // Sticky carrier history, cleared per attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen_q <= 1'b0;
            lost_q <= 1'b0;
        end else if (enable) begin
            seen_q <= seen_q | crs;
            lost_q <= lost_q | ~crs;
        end
    end

    assign seen = seen_q | (enable & crs);
    assign lost = lost_q | (enable & ~crs);

endmodule

// File: rtl/hd_tx_status_tracker.sv
// Half-duplex transmit status tracker.
// Steps one frame through defer and transmit for each attempt. It ends every attempt
// with one of retry / abort / done and a packed status word on the same edge.
// Assumes: att_start is honoured only when idle. Inputs are synchronous to clk.
// COLL_LIMIT is at most 16 so that the 4-bit count field covers every retry.
module hd_tx_status_tracker
    import hdts_pkg::*;
#(
    parameter int COLL_LIMIT       = 16,
    parameter int WINDOW_BYTES     = 64,
    parameter int DEFER_LIMIT_BITS = 24288,
    parameter int BITS_PER_CLK     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                att_start,
    input  logic                att_new_frame,
    input  logic                tx_active,
    input  logic                byte_stb,
    input  logic                crs,
    input  logic                col,
    input  logic                underflow,
    input  logic                vlan,
    input  logic                cfg_no_retry,
    input  logic                cfg_defer_chk,
    output logic                tx_go,
    output logic                retry_pulse,
    output logic                abort_pulse,
    output logic                done_pulse,
    output logic [STATUS_W-1:0] status
);
    localparam int CC_W = $clog2(COLL_LIMIT + 1);
    localparam logic [CC_W-1:0] LIMIT_V = CC_W'(COLL_LIMIT);

    hdts_state_e   state_q, state_d;
    logic [CC_W-1:0] coll_q, coll_next, coll_rep;
    logic [3:0]    coll_field;
    logic          deferred_q, vlan_q;
    hdts_status_t  status_q, word_d;
    logic          retry_q, abort_q, done_q;

    logic in_defer, in_xmit, attempt_open, frame_open;
    logic defer_expired, past_window, crs_seen, crs_lost;
    logic defer_abort, uf_ev, col_ev, late_ev, win_col, excess_ev;
    logic retry_ev, done_ev, end_ev, abort_ev;

    assign in_defer     = (state_q == ST_DEFER);
    assign in_xmit      = (state_q == ST_XMIT);
    assign attempt_open = (state_q == ST_IDLE) && att_start;
    assign frame_open   = attempt_open && att_new_frame;

    hdts_defer_timer #(
        .DEFER_LIMIT_BITS (DEFER_LIMIT_BITS),
        .BITS_PER_CLK     (BITS_PER_CLK)
    ) u_defer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (attempt_open),
        .tick    (in_defer && crs),
        .expired (defer_expired)
    );

    hdts_byte_window #(
        .WINDOW_BYTES (WINDOW_BYTES)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (attempt_open),
        .stb         (in_xmit && byte_stb),
        .past_window (past_window)
    );

    hdts_carrier_mon u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (attempt_open),
        .enable (in_xmit),
        .crs    (crs),
        .seen   (crs_seen),
        .lost   (crs_lost)
    );

    // Event decode for the current cycle, underflow first, then collision, then end.
    always_comb begin
        defer_abort = in_defer && crs && cfg_defer_chk && defer_expired;
        uf_ev       = in_xmit && underflow;
        col_ev      = in_xmit && col && !underflow;
        late_ev     = col_ev && past_window;
        win_col     = col_ev && !past_window;
        coll_next   = coll_q + 1'b1;
        excess_ev   = win_col && (cfg_no_retry || coll_next == LIMIT_V);
        retry_ev    = win_col && !excess_ev;
        done_ev     = in_xmit && !underflow && !col && !tx_active;
        abort_ev    = defer_abort || uf_ev || late_ev || excess_ev;
        end_ev      = abort_ev || retry_ev || done_ev;
    end

    // Count value to report: the incremented count on an in-window collision.
    assign coll_rep = win_col ? coll_next : coll_q;

    // Fit the internal count into the 4-bit field whatever its width.
    generate
        if (CC_W >= 4) begin : g_cnt_trim
            assign coll_field = coll_rep[3:0];
        end else begin : g_cnt_pad
            assign coll_field = {{(4 - CC_W){1'b0}}, coll_rep};
        end
    endgenerate

    // Build the word published at the end of the attempt, with cross-field rules.
    always_comb begin
        word_d              = '0;
        word_d.is_vlan      = vlan_q;
        word_d.deferred     = deferred_q || (in_defer && crs);
        word_d.coll_count   = excess_ev ? 4'd0 : coll_field;
        if (defer_abort) begin
            word_d.defer_excess = 1'b1;
        end else begin
            word_d.data_late    = uf_ev;
            word_d.coll_late    = late_ev;
            word_d.coll_excess  = excess_ev;
            word_d.carrier_none = !crs_seen;
            word_d.carrier_lost = crs_seen && crs_lost && !col_ev && (coll_q == '0);
        end
    end

    // Next-state selection for the attempt sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (att_start)   state_d = ST_DEFER;
            ST_DEFER: if (defer_abort) state_d = ST_IDLE;
                      else if (!crs)   state_d = ST_XMIT;
            ST_XMIT:  if (end_ev)      state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-attempt flags: deferral seen and VLAN sampled at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deferred_q <= 1'b0;
            vlan_q     <= 1'b0;
        end else if (attempt_open) begin
            deferred_q <= 1'b0;
            vlan_q     <= vlan;
        end else if (in_defer && crs) begin
            deferred_q <= 1'b1;
        end
    end

    // Collision count, cleared per frame and kept across retries.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_open) coll_q <= '0;
        else if (win_col)         coll_q <= coll_next;
    end

    // Published status word: cleared on a new frame, written at each attempt end.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_open) status_q <= '0;
        else if (end_ev)          status_q <= word_d;
    end

    // One-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= 1'b0;
            abort_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            retry_q <= retry_ev;
            abort_q <= abort_ev;
            done_q  <= done_ev;
        end
    end

    assign tx_go       = in_xmit;
    assign retry_pulse = retry_q;
    assign abort_pulse = abort_q;
    assign done_pulse  = done_q;
    assign status      = status_q;

endmodule

// File: rtl/hdts_checker.sv
// Property checker for the transmit status tracker, bound to the top module.
// Assumes: only the top-level ports are visible.
module hdts_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        att_start,
    input logic        crs,
    input logic        tx_go,
    input logic        retry_pulse,
    input logic        abort_pulse,
    input logic        done_pulse,
    input logic [11:0] status
);
    // R14: outputs are zero after a reset cycle.
    a_r14_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (status == 12'h000 && !tx_go && !retry_pulse && !abort_pulse && !done_pulse));

    // R12: at most one outcome pulse at a time.
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retry_pulse, abort_pulse, done_pulse}));

    // R12: pulses last a single cycle.
    a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_pulse || abort_pulse || done_pulse) |=> !(retry_pulse || abort_pulse || done_pulse));

    // R2: transmission is granted only after a quiet-carrier cycle.
    a_r2_go_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_go) |-> $past(!crs));

    // R6: the count reads zero once excessive collision is flagged.
    a_r6_count_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        status[8] |-> (status[6:3] == 4'd0));

    // R8: late collision never shown together with underflow.
    a_r8_late_masked: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> !status[9]);

    // R9: loss of carrier only for collision-free frames.
    a_r9_lost_clean: assert property (@(posedge clk) disable iff (!rst_n)
        status[11] |-> (status[6:3] == 4'd0 && !status[9] && !status[8]));

    // R10: no carrier excludes loss of carrier.
    a_r10_none_excl: assert property (@(posedge clk) disable iff (!rst_n)
        status[10] |-> !status[11]);

    // R3: an excessive deferral is reported with the deferred bit.
    a_r3_defer_pair: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[0]);

    // R13: status changes only at an attempt end or after a start.
    a_r13_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!retry_pulse && !abort_pulse && !done_pulse && !$past(att_start)) |-> $stable(status));

endmodule

bind hd_tx_status_tracker hdts_checker u_hdts_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .att_start   (att_start),
    .crs         (crs),
    .tx_go       (tx_go),
    .retry_pulse (retry_pulse),
    .abort_pulse (abort_pulse),
    .done_pulse  (done_pulse),
    .status      (status)
);

// File: tb/tb_hd_tx_status_tracker.sv
module tb_hd_tx_status_tracker;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic att_start = 0, att_new_frame = 0, tx_active = 0, byte_stb = 0;
    logic crs = 0, col = 0, underflow = 0, vlan = 0, cfg_no_retry = 0, cfg_defer_chk = 0;
    logic tx_go, retry_pulse, abort_pulse, done_pulse;
    logic [11:0] status;

    int checks = 0;
    int fails  = 0;
    int npulse = 0;
    logic [1:0]  got_res;
    logic [11:0] got_st;

    always #4 clk = ~clk;

    hd_tx_status_tracker #(
        .COLL_LIMIT       (16),
        .WINDOW_BYTES     (8),
        .DEFER_LIMIT_BITS (40),
        .BITS_PER_CLK     (4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .att_start(att_start), .att_new_frame(att_new_frame),
        .tx_active(tx_active), .byte_stb(byte_stb), .crs(crs), .col(col),
        .underflow(underflow), .vlan(vlan), .cfg_no_retry(cfg_no_retry),
        .cfg_defer_chk(cfg_defer_chk), .tx_go(tx_go), .retry_pulse(retry_pulse),
        .abort_pulse(abort_pulse), .done_pulse(done_pulse), .status(status)
    );

    // Outcome capture: res 1 retry, 2 abort, 3 done.
    always @(posedge clk) begin
        #1;
        if (retry_pulse || abort_pulse || done_pulse) begin
            npulse++;
            got_res = retry_pulse ? 2'd1 : (abort_pulse ? 2'd2 : 2'd3);
            got_st  = status;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ev: 0 end, 1 collision, 2 underflow, 3 both. cm: 0 carrier on, 1 drop at end, 2 absent.
    typedef struct packed {
        logic       new_f;
        logic       vl;
        logic       nr;
        logic       dc;
        logic [4:0] dcyc;
        logic [3:0] nbytes;
        logic [1:0] ev;
        logic [1:0] cm;
        logic [1:0] res;
        logic [11:0] st;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd3, 2'd0, 2'd0, 2'd3, 12'h000}, // R12 R1 plain done
        '{1'b1, 1'b1, 1'b0, 1'b0, 5'd2,  4'd3, 2'd0, 2'd0, 2'd3, 12'h081}, // R2 R11 deferred, VLAN
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd3, 2'd1, 2'd0, 2'd1, 12'h008}, // R4 first collision
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd2, 2'd1, 2'd0, 2'd1, 12'h010}, // R4 R13 count kept
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd4, 2'd0, 2'd1, 2'd3, 12'h010}, // R9 no loss after collisions
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd4, 2'd0, 2'd1, 2'd3, 12'h800}, // R9 R13 loss of carrier
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd4, 2'd0, 2'd2, 2'd3, 12'h400}, // R10 no carrier
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd8, 2'd1, 2'd0, 2'd2, 12'h200}, // R5 late at window
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd7, 2'd1, 2'd0, 2'd1, 12'h008}, // R5 R4 just inside
        '{1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  4'd2, 2'd1, 2'd0, 2'd2, 12'h100}, // R7 no retry
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd3, 2'd2, 2'd0, 2'd2, 12'h002}, // R8 underflow
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd9, 2'd3, 2'd0, 2'd2, 12'h002}, // R8 underflow over late
        '{1'b1, 1'b0, 1'b0, 1'b1, 5'd11, 4'd1, 2'd0, 2'd0, 2'd2, 12'h005}, // R3 limit exceeded
        '{1'b1, 1'b0, 1'b0, 1'b1, 5'd10, 4'd1, 2'd0, 2'd0, 2'd3, 12'h001}, // R3 at the limit
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd15, 4'd1, 2'd0, 2'd0, 2'd3, 12'h001}, // R3 check off
        '{1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  4'd2, 2'd0, 2'd0, 2'd3, 12'h000}  // R7 no effect without collision
    };

    task automatic run_attempt(input vec_t v);
        @(negedge clk);
        npulse = 0;
        att_start = 1; att_new_frame = v.new_f; vlan = v.vl;
        cfg_no_retry = v.nr; cfg_defer_chk = v.dc; crs = 0; tx_active = 1;
        @(negedge clk);
        att_start = 0; vlan = 0;
        for (int i = 0; i < int'(v.dcyc); i++) begin
            crs = 1;
            @(negedge clk);
        end
        crs = 0;
        @(negedge clk);
        for (int i = 0; i < int'(v.nbytes); i++) begin
            crs = (v.cm == 2'd2) ? 1'b0 : 1'b1;
            byte_stb = 1;
            @(negedge clk);
        end
        byte_stb = 0;
        crs = (v.cm == 2'd0);
        col = (v.ev == 2'd1) || (v.ev == 2'd3);
        underflow = (v.ev >= 2'd2);
        tx_active = (v.ev != 2'd0);
        @(negedge clk);
        col = 0; underflow = 0; tx_active = 0; crs = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R14 reset state
        check("R14", {tx_go, retry_pulse, abort_pulse, done_pulse, status}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check("R14", {20'h0, status}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            run_attempt(VECS[k]);
            check($sformatf("R12 vec%0d pulses", k), npulse, 1);
            check($sformatf("R1 vec%0d outcome", k), {30'h0, got_res}, {30'h0, VECS[k].res});
            check($sformatf("R1 vec%0d status", k), {20'h0, got_st}, {20'h0, VECS[k].st});
        end

        // R6: fifteen retries then the collision limit aborts
        for (int k = 1; k <= 16; k++) begin
            v = '{1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd1, 2'd1, 2'd0, 2'd1, 12'h000};
            v.new_f = (k == 1);
            if (k < 16) begin
                v.st = {5'b0, 4'(k), 3'b0};
            end else begin
                v.res = 2'd2; v.st = 12'h100;
            end
            run_attempt(v);
            check($sformatf("R6 collision %0d outcome", k), {30'h0, got_res}, {30'h0, v.res});
            check($sformatf("R6 collision %0d status", k), {20'h0, got_st}, {20'h0, v.st});
        end

        // R13 new frame clears status; R2 grant waits for quiet carrier
        @(negedge clk);
        att_start = 1; att_new_frame = 1; tx_active = 1; crs = 1; cfg_defer_chk = 0;
        @(negedge clk);
        att_start = 0;
        check("R13 cleared on new frame", {20'h0, status}, 32'h0);
        @(negedge clk);
        check("R2 no grant under carrier", {31'h0, tx_go}, 32'h0);
        crs = 0;
        @(negedge clk);
        check("R2 grant after quiet cycle", {31'h0, tx_go}, 32'h1);
        crs = 1; tx_active = 0;
        @(negedge clk);
        check("R12 done after grant", {31'h0, done_pulse}, 32'h1);
        check("R2 deferred flag", {20'h0, status}, 32'h001);
        crs = 0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule